// File: doc/BRIEF.md
# Chainable Serial Gain-Control Port

This block is the digital control port of a programmable-gain amplifier stage. A bus master drives a serial clock, a serial data line and an active-low load-enable line. While load enable is low, each rising edge of the serial clock moves one bit into an 8-bit shift register. When load enable rises, the shifted word moves into the active registers. These registers drive a 6-bit gain code and a power-down flag. The analog gain is 10 dB plus a quarter dB per code step. The block also outputs that gain as a count of quarter-dB units so that it can be checked directly.

The final shift-register stage drives a serial data output. That output changes on the falling edge of the serial clock, so a second port wired behind this one samples it on the next rising edge. A master can therefore feed several ports in a chain from one bus and load all of them with a single rise of load enable. The block runs on a fast system clock. It synchronises the three serial inputs and finds their edges internally.

Top module: `gain_ctl_port`

## Requirements
- R1: A control word is 8 bits, and exactly 8 rising serial-clock edges fill it. The first bit shifted in is the power-down flag. The second is a reserved bit. The last six are the gain code, most-significant bit first.
- R2: Serial data is sampled only on rising edges of the serial clock, and only while load enable is low.
- R3: The reserved bit has no effect on the gain code or the power-down flag.
- R4: While load enable is high, serial-clock and serial-data activity changes neither the shift register nor the serial output.
- R5: A low-to-high transition of load enable copies the shifted power-down flag and gain code into the active outputs. At all other times the active outputs hold their values, including while bits are being shifted.
- R6: The serial output carries the last shift stage, that is, the bit shifted in 8 rising edges earlier. It is updated on falling serial-clock edges, so two chained ports, loaded with 16 bits, each hold their own word.
- R7: After reset the gain code is 31 (17.75 dB), the power-down flag is 0 and the serial output is 0.
- R8: The quarter-dB output equals 40 plus the active gain code, which gives 40 for code 0 and 103 for code 63.
- R9: A word with the power-down flag set still loads its gain code, so the gain code stays visible while the part is powered down. A later word with the flag clear restores normal operation at the code that word loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the bus master |
| ser_din | input | 1 | Serial data in |
| load_en | input | 1 | Load enable: shifting while low, latch on its rise |
| ser_dout | output | 1 | Serial data out to the next port in the chain |
| gain_code | output | 6 | Active gain code |
| pwr_down | output | 1 | Active power-down flag |
| gain_qdb | output | 7 | Active gain in quarter-dB units |

## Verification
The assertions assume the following about the inputs, after synchronisation:
- Each high phase and each low phase of the serial clock lasts several system clocks.
- Serial data is settled well before each rising serial-clock edge.
- Load enable changes only while the serial clock is low.

These assumptions let the assertions tie every change of the shift register, the serial output and the active outputs to one detected edge strobe. The stimulus meets them by design:
- Every serial-clock phase is held for eight system clocks.
- New data is driven at the falling edge.
- Load enable is moved only after the clock has been low for a full phase.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    // Edge strobes derived from the synchronised serial inputs
    typedef struct packed {
        logic shift;   // rising serial clock while load enable low
        logic drive;   // falling serial clock while load enable low
        logic latch;   // rising load enable
    } gcp_strobe_t;

endpackage

// File: rtl/gcp_sync.sv
module gcp_sync #(
    parameter int          WIDTH  = 3,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/gcp_edge.sv
module gcp_edge
    import gcp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_s,
    input  logic        ld_s,
    output gcp_strobe_t stb
);

    typedef struct packed {
        logic sclk_p;
        logic ld_p;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.sclk_p = sclk_s;
        st_d.ld_p   = ld_s;
        stb.shift   = sclk_s & ~st_q.sclk_p & ~ld_s;
        stb.drive   = ~sclk_s & st_q.sclk_p & ~ld_s;
        stb.latch   = ld_s & ~st_q.ld_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_p <= 1'b0;
            st_q.ld_p   <= 1'b1;   // idle-high enable must not look like a rise
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gcp_shift.sv
module gcp_shift #(
    parameter int WORD_W = 8,
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              drive,
    input  logic              din,
    output logic              dout,
    output logic              word_pd,
    output logic [GAIN_W-1:0] word_gain
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              so;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], din};
        end
        if (drive) begin
            st_d.so = st_q.sr[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= '0;
            st_q.so <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // First bit in ends at the far stage; gain occupies the newest bits
    assign dout      = st_q.so;
    assign word_pd   = st_q.sr[WORD_W-1];
    assign word_gain = st_q.sr[GAIN_W-1:0];

endmodule

// File: rtl/gain_ctl_port.sv
module gain_ctl_port
    import gcp_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int GAIN_W      = 6,
    parameter int DEF_GAIN    = 31,
    parameter int SYNC_STAGES = 2,
    parameter int QDB_BASE    = 40,
    localparam int QDB_W      = $clog2(QDB_BASE + (1 << GAIN_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              load_en,
    output logic              ser_dout,
    output logic [GAIN_W-1:0] gain_code,
    output logic              pwr_down,
    output logic [QDB_W-1:0]  gain_qdb
);

    localparam int IN_W = 3;

    typedef struct packed {
        logic              pd;
        logic [GAIN_W-1:0] gain;
    } active_t;

    logic [IN_W-1:0]   in_s;
    gcp_strobe_t       stb;
    logic              word_pd;
    logic [GAIN_W-1:0] word_gain;
    active_t           act_d, act_q;

    gcp_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({load_en, ser_din, ser_clk}),
        .dout  (in_s)
    );

    gcp_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (in_s[0]),
        .ld_s   (in_s[2]),
        .stb    (stb)
    );

    gcp_shift #(
        .WORD_W (WORD_W),
        .GAIN_W (GAIN_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (stb.shift),
        .drive     (stb.drive),
        .din       (in_s[1]),
        .dout      (ser_dout),
        .word_pd   (word_pd),
        .word_gain (word_gain)
    );

    always_comb begin
        act_d = act_q;
        if (stb.latch) begin
            act_d.pd   = word_pd;
            act_d.gain = word_gain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.pd   <= 1'b0;
            act_q.gain <= GAIN_W'(DEF_GAIN);
        end else begin
            act_q <= act_d;
        end
    end

    assign gain_code = act_q.gain;
    assign pwr_down  = act_q.pd;
    assign gain_qdb  = QDB_W'(QDB_BASE) + QDB_W'(act_q.gain);

endmodule

// File: rtl/gcp_checker.sv
module gcp_checker #(
    parameter int GAIN_W   = 6,
    parameter int DEF_GAIN = 31,
    parameter int QDB_BASE = 40,
    parameter int QDB_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_s,
    input logic              shift,
    input logic              drive,
    input logic              latch,
    input logic              word_pd,
    input logic [GAIN_W-1:0] word_gain,
    input logic              ser_dout,
    input logic [GAIN_W-1:0] gain_code,
    input logic              pwr_down,
    input logic [QDB_W-1:0]  gain_qdb
);

    p_reset_default_r7: assert property (@(posedge clk)
        !rst_n |=> (gain_code == GAIN_W'(DEF_GAIN)) && !pwr_down && !ser_dout);

    p_latch_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (gain_code == $past(word_gain)) && (pwr_down == $past(word_pd)));

    p_hold_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(gain_code) && $stable(pwr_down));

    p_shift_only_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(word_gain) && $stable(word_pd));

    p_enable_high_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_s |=> $stable(word_gain) && $stable(word_pd) && $stable(ser_dout));

    p_dout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> $stable(ser_dout));

    p_qdb_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_qdb >= QDB_W'(QDB_BASE)) && (gain_qdb <= QDB_W'(QDB_BASE + (1 << GAIN_W) - 1)));

endmodule

bind gain_ctl_port gcp_checker #(
    .GAIN_W   (GAIN_W),
    .DEF_GAIN (DEF_GAIN),
    .QDB_BASE (QDB_BASE),
    .QDB_W    (QDB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_s      (in_s[2]),
    .shift     (stb.shift),
    .drive     (stb.drive),
    .latch     (stb.latch),
    .word_pd   (word_pd),
    .word_gain (word_gain),
    .ser_dout  (ser_dout),
    .gain_code (gain_code),
    .pwr_down  (pwr_down),
    .gain_qdb  (gain_qdb)
);

// File: tb/tb_gain_ctl_port.sv
module tb_gain_ctl_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per serial-clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_m = 1'b0;
    logic       sdata_m = 1'b0;
    logic       ld_m = 1'b1;
    logic       link;
    logic       dout_tail;
    logic [5:0] g_head, g_tail;
    logic       pd_head, pd_tail;
    logic [6:0] q_head, q_tail;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_ctl_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk_m), .ser_din(sdata_m), .load_en(ld_m),
        .ser_dout(link), .gain_code(g_head), .pwr_down(pd_head), .gain_qdb(q_head)
    );

    gain_ctl_port dut_tail (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk_m), .ser_din(link), .load_en(ld_m),
        .ser_dout(dout_tail), .gain_code(g_tail), .pwr_down(pd_tail), .gain_qdb(q_tail)
    );

    function automatic int exp_gain(input logic [7:0] w);
        return int'(w[5:0]);
    endfunction

    function automatic int exp_pd(input logic [7:0] w);
        return int'(w[7]);
    endfunction

    function automatic int exp_qdb(input logic [7:0] w);
        return 40 + int'(w[5:0]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdata_m = b;
        wait_clk(HALF);
        sclk_m = 1'b1;
        wait_clk(HALF);
        sclk_m = 1'b0;
    endtask

    // Far word goes first so that it travels through the head port
    task automatic send_chain(input logic [7:0] w_tail, input logic [7:0] w_head);
        ld_m = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) shift_bit(w_tail[i]);
        for (int i = 7; i >= 0; i--) shift_bit(w_head[i]);
        wait_clk(HALF);
    endtask

    task automatic raise_load();
        ld_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic check_both(input string tag, input logic [7:0] wt, input logic [7:0] wh);
        check({tag, " head gain"}, int'(g_head), exp_gain(wh));
        check({tag, " head pd"},   int'(pd_head), exp_pd(wh));
        check({tag, " head qdb"},  int'(q_head), exp_qdb(wh));
        check({tag, " tail gain"}, int'(g_tail), exp_gain(wt));
        check({tag, " tail pd"},   int'(pd_tail), exp_pd(wt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] wh, wt;
        void'($urandom(32'h1234_5EED));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(6);

        // R7 / R8: reset state
        check("R7 reset gain", int'(g_head), 31);
        check("R7 reset pd", int'(pd_head), 0);
        check("R7 reset dout", int'(link), 0);
        check("R8 reset qdb", int'(q_head), 71);

        // Directed chain load, reserved bit set in the tail word (R1 R3 R6)
        wt = {1'b0, 1'b1, 6'd5};
        wh = {1'b0, 1'b0, 6'd63};
        send_chain(wt, wh);
        check("R5 no change while shifting", int'(g_head), 31);
        check("R5 tail no change while shifting", int'(g_tail), 31);
        check("R6 head dout last stage", int'(link), int'(wh[7]));
        check("R6 tail dout last stage", int'(dout_tail), int'(wt[7]));
        raise_load();
        check_both("R1 R2 R3 R6 chain load", wt, wh);
        check("R8 max code qdb", int'(q_head), 103);

        // R4: activity with enable high is ignored; relatch must show old word
        for (int i = 0; i < 10; i++) shift_bit(1'($urandom()));
        check("R4 dout unchanged", int'(link), int'(wh[7]));
        ld_m = 1'b0;
        wait_clk(HALF);
        raise_load();
        check_both("R4 ignored while enable high", wt, wh);

        // R8 minimum code, R3 reserved bit in head
        wt = {1'b0, 1'b0, 6'd63};
        wh = {1'b0, 1'b1, 6'd0};
        send_chain(wt, wh);
        raise_load();
        check_both("R8 R3 min code", wt, wh);
        check("R8 min code qdb", int'(q_head), 40);

        // R9: power-down still loads gain, wake restores
        wt = {1'b0, 1'b1, 6'd7};
        wh = {1'b1, 1'b0, 6'd20};
        send_chain(wt, wh);
        check("R6 power flag reaches dout", int'(link), 1);
        raise_load();
        check("R9 power down set", int'(pd_head), 1);
        check("R9 gain visible in power down", int'(g_head), 20);
        wh = {1'b0, 1'b0, 6'd20};
        send_chain(wt, wh);
        check("R9 still down before load", int'(pd_head), 1);
        raise_load();
        check("R9 wake pd", int'(pd_head), 0);
        check("R9 wake gain", int'(g_head), 20);

        // Random words
        for (int n = 0; n < 25; n++) begin
            wt = 8'($urandom());
            wh = 8'($urandom());
            send_chain(wt, wh);
            check("R6 random head dout", int'(link), int'(wh[7]));
            check("R6 random tail dout", int'(dout_tail), int'(wt[7]));
            raise_load();
            check_both("R1 R2 R5 R8 random", wt, wh);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule